// File: doc/BRIEF.md
# SPI Slave Transmitter with Holding Register

This block is the slave side of an SPI link, with a one-byte transmit holding register in front of the shift register. The host writes the next outgoing byte into the holding register at any time. The shift engine copies it into the shift register only at the start of a frame. Once a frame has started, the shift register is locked against host writes. A byte written during a frame waits in the holding register and goes out in the next frame.

SCK, slave select and MOSI are brought into the system clock domain through a synchronizer chain, and all edge decisions are made on the synchronized copies. The clock polarity input selects which SCK edge is the leading one. The clock phase input selects the timing:

- **Phase zero:** the frame starts when slave select is asserted. Data is sampled on the leading edge and shifted on the trailing edge.
- **Phase one:** the frame starts on the first leading edge. That edge loads the shift register and drives the MSB. Data is sampled on the trailing edge.

Every frame is eight bits, MSB first in both directions.

Top module: `spi_slave_dbtx`

## Requirements
- R1: After reset `tx_empty_o` is 1, `rx_done_o` is 0, `miso_oe_o` is 0 and `rx_data_o` is 0x00.
- R2: A host write (`wr_en_i` high for one clock) drives `tx_empty_o` to 0. Copying the holding register into the shift register drives it back to 1, unless a write lands in that same cycle.
- R3: With `cpha_i`=0:
  - the shift register loads once per slave-select assertion;
  - the MSB is on `miso_o` before the first SCK edge;
  - MOSI is sampled on each leading edge and MISO advances on each trailing edge.
- R4: With `cpha_i`=1:
  - the holding register is left untouched while slave select is low and SCK is idle;
  - the first leading edge loads the shift register and drives the MSB;
  - MOSI is sampled on trailing edges;
  - further frames may follow under one slave-select assertion.
- R5: Frames are 8 bits, MSB first in both directions. `rx_data_o` holds the last complete received byte and changes only together with `rx_done_o`.
- R6: A write made after a frame has begun does not alter the byte being shifted out. It stays in the holding register (`tx_empty_o`=0) and is transmitted in the next frame.
- R7: `rx_done_o` is high for exactly one system clock per completed 8-bit frame.
- R8: Deasserting slave select (`ss_ni`=1) does the following:
  - drops `miso_oe_o`;
  - discards a partial frame without raising `rx_done_o`;
  - resets the bit counter, so the next frame starts at bit 7.
- R9: If the holding register is empty when a frame loads, the frame transmits 0xFF.
- R10: A write in the same cycle as a load does two things:
  - the shift register takes the previous holding contents;
  - the new byte stays in the holding register with `tx_empty_o`=0 for the next frame.
- R11: With `cpol_i`=1, SCK idles high and the falling edge is the leading edge. Both phases behave as in R3 and R4 with the edge roles mirrored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | SCK idle level (1 = idle high, falling edge leads) |
| cpha_i | input | 1 | Clock phase (0 = sample on leading edge, 1 = sample on trailing edge) |
| wr_data_i | input | 8 | Byte to transmit |
| wr_en_i | input | 1 | Write strobe into the holding register |
| tx_empty_o | output | 1 | Holding register empty |
| rx_data_o | output | 8 | Last received byte |
| rx_done_o | output | 1 | One-cycle pulse when a byte has been received |
| sck_i | input | 1 | Serial clock from master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for MISO (0 = high impedance) |

## Verification
A host write and the copy of the holding register into the shift register can fall in the same system clock.

The bench provokes this in phase-zero mode. It asserts slave select and then raises the write strobe in exactly the cycle the synchronized select triggers the load, counting the two synchronizer stages. It then judges two frames:
- the first frame must carry the byte that was already waiting, with `tx_empty_o` still 0 afterwards;
- the second frame must carry the colliding byte.

The mid-frame deferral case, where a write arrives between SCK edges of a running phase-one frame, is judged the same way across two back-to-back frames.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic sample;
    logic drive;
  } sck_evt_t;

  // map raw rise/fall onto sample/drive roles for the selected mode
  function automatic sck_evt_t classify_edge(logic cpol, logic cpha, logic rise, logic fall);
    sck_evt_t e;
    logic lead;
    logic trail;
    lead     = cpol ? fall : rise;
    trail    = cpol ? rise : fall;
    e.sample = cpha ? trail : lead;
    e.drive  = cpha ? lead : trail;
    return e;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES:0][W-1:0] chain;

  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= RST_VAL;
      else         chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];

endmodule

// File: rtl/spi_sck_edge.sv
module spi_sck_edge
  import spi_slave_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sample_o,
  output logic drive_o
);

  logic     sck_q;
  sck_evt_t evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  always_comb evt = classify_edge(cpol_i, cpha_i, sck_s_i & ~sck_q, ~sck_s_i & sck_q);

  assign sample_o = evt.sample;
  assign drive_o  = evt.drive;

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] load_data_o,
  output logic              empty_o
);

  logic [DATA_W-1:0] hold_q;
  logic              full_q;

  // a write wins over a take in the same cycle; the take still sees old contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (wr_en_i) begin
      hold_q <= wr_data_i;
      full_q <= 1'b1;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign load_data_o = full_q ? hold_q : FILL;
  assign empty_o     = ~full_q;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ss_act_i,
  input  logic              cpha_i,
  input  logic              sample_i,
  input  logic              drive_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              take_o,
  output logic              miso_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              ss_prev_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-2:0] rx_q;
  logic              start_sel;
  logic              start_edge;
  logic              shift_en;
  logic              sample_en;

  // phase 0: load on select assertion; phase 1: load on first drive edge
  assign start_sel  = ss_act_i & ~ss_prev_q & ~cpha_i;
  assign start_edge = ss_act_i & cpha_i & ~busy_q & drive_i;
  assign take_o     = start_sel | start_edge;
  assign shift_en   = ss_act_i & busy_q & drive_i;
  assign sample_en  = ss_act_i & busy_q & sample_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_prev_q <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      rx_data_o <= '0;
      rx_done_o <= 1'b0;
    end else begin
      ss_prev_q <= ss_act_i;
      rx_done_o <= 1'b0;
      if (!ss_act_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (take_o) begin
        tx_q   <= load_data_i;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        if (shift_en) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        if (sample_en) begin
          if (cnt_q == LAST) begin
            cnt_q     <= '0;
            busy_q    <= 1'b0;
            rx_data_o <= {rx_q, mosi_i};
            rx_done_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            rx_q  <= {rx_q[DATA_W-3:0], mosi_i};
          end
        end
      end
    end
  end

  assign miso_o = tx_q[DATA_W-1];
  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/spi_slave_dbtx.sv
module spi_slave_dbtx
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W      = FRAME_BITS,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH,
  parameter logic [DATA_W-1:0] IDLE_FILL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  output logic              tx_empty_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [2:0]        pins_s;
  logic              sck_s;
  logic              ss_act;
  logic              mosi_s;
  logic              sample_en;
  logic              drive_en;
  logic              take;
  logic              busy;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] load_data;

  spi_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i}),
    .q_o   (pins_s)
  );

  assign sck_s  = pins_s[2];
  assign ss_act = ~pins_s[1];
  assign mosi_s = pins_s[0];

  spi_sck_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_s_i (sck_s),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .sample_o(sample_en),
    .drive_o (drive_en)
  );

  spi_tx_hold #(
    .DATA_W(DATA_W),
    .FILL  (IDLE_FILL)
  ) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .take_i     (take),
    .load_data_o(load_data),
    .empty_o    (tx_empty_o)
  );

  spi_shift_core #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ss_act_i   (ss_act),
    .cpha_i     (cpha_i),
    .sample_i   (sample_en),
    .drive_i    (drive_en),
    .mosi_i     (mosi_s),
    .load_data_i(load_data),
    .take_o     (take),
    .miso_o     (miso_o),
    .busy_o     (busy),
    .cnt_o      (bit_cnt),
    .rx_data_o  (rx_data_o),
    .rx_done_o  (rx_done_o)
  );

  assign miso_oe_o = ss_act;

endmodule

// File: rtl/spi_slave_dbtx_chk.sv
module spi_slave_dbtx_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              tx_empty_o,
  input logic              rx_done_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              miso_o,
  input logic              ss_act,
  input logic              drive_en,
  input logic              take,
  input logic              busy,
  input logic [CNT_W-1:0]  bit_cnt
);

  a_r2_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tx_empty_o);

  a_r2_load_sets_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !wr_en_i |=> tx_empty_o);

  a_r10_collision_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && wr_en_i |=> !tx_empty_o);

  a_r9_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o && !wr_en_i |=> tx_empty_o);

  a_r6_locked_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !drive_en |=> $stable(miso_o));

  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  a_r5_rx_changes_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> rx_done_o);

  a_r8_deselect_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act |=> !busy && (bit_cnt == '0));

endmodule

bind spi_slave_dbtx spi_slave_dbtx_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .tx_empty_o(tx_empty_o),
  .rx_done_o (rx_done_o),
  .rx_data_o (rx_data_o),
  .miso_o    (miso_o),
  .ss_act    (ss_act),
  .drive_en  (drive_en),
  .take      (take),
  .busy      (busy),
  .bit_cnt   (bit_cnt)
);

// File: tb/spi_slave_dbtx_test.sv
`timescale 1ns/1ps
module spi_slave_dbtx_test;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       cpol_i, cpha_i;
  logic [7:0] wr_data_i;
  logic       wr_en_i;
  logic       tx_empty_o;
  logic [7:0] rx_data_o;
  logic       rx_done_o;
  logic       sck_i, ss_ni, mosi_i;
  logic       miso_o, miso_oe_o;

  int checks   = 0;
  int errors   = 0;
  int done_cnt = 0;

  always #2 clk = ~clk;

  spi_slave_dbtx uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .wr_data_i(wr_data_i), .wr_en_i(wr_en_i), .tx_empty_o(tx_empty_o),
    .rx_data_o(rx_data_o), .rx_done_o(rx_done_o), .sck_i(sck_i),
    .ss_ni(ss_ni), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );

  always @(posedge clk) if (rst_ni && rx_done_o) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] d);
    wr_data_i = d;
    wr_en_i   = 1'b1;
    wclk(1);
    wr_en_i   = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    ss_ni  = 1'b1;
    cpol_i = pol;
    cpha_i = pha;
    sck_i  = pol;
    wclk(6);
  endtask

  task automatic release_ss();
    ss_ni = 1'b1;
    sck_i = cpol_i;
    wclk(6);
  endtask

  // master model; mid write lands at bit 4, collision write lands on the select-load cycle
  task automatic run_frame(input logic [7:0] mosi_b, input int nbits,
                           input logic mid_wr, input logic [7:0] mid_b,
                           input logic coll, input logic [7:0] coll_b,
                           output logic [7:0] miso_b);
    miso_b = '0;
    ss_ni  = 1'b0;
    if (coll) begin
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      host_wr(coll_b);
      wclk(2*H - 2);
    end else begin
      wclk(2*H);
    end
    for (int i = 0; i < nbits; i++) begin
      if (!cpha_i) begin
        mosi_i = mosi_b[7-i];
        if (mid_wr && i == 4) begin host_wr(mid_b); wclk(H-1); end
        else wclk(H);
        miso_b[7-i] = miso_o;
        sck_i = ~cpol_i;
        wclk(H);
        sck_i = cpol_i;
      end else begin
        sck_i  = ~cpol_i;
        mosi_i = mosi_b[7-i];
        if (mid_wr && i == 4) begin host_wr(mid_b); wclk(H-1); end
        else wclk(H);
        miso_b[7-i] = miso_o;
        sck_i = cpol_i;
        wclk(H);
      end
    end
    wclk(H);
  endtask

  task automatic t_reset();
    chk("R1 tx_empty", tx_empty_o, 1);
    chk("R1 rx_done", rx_done_o, 0);
    chk("R1 miso_oe", miso_oe_o, 0);
    chk("R1 rx_data", rx_data_o, 8'h00);
  endtask

  task automatic t_basic(input string req, input logic pol, input logic pha,
                         input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got;
    int d0;
    set_mode(pol, pha);
    host_wr(tx);
    chk({req, "/R2 write clears empty"}, tx_empty_o, 0);
    d0 = done_cnt;
    run_frame(rx, 8, 1'b0, 8'h00, 1'b0, 8'h00, got);
    chk({req, "/R5 miso byte"}, got, tx);
    chk({req, "/R5 rx byte"}, rx_data_o, rx);
    chk({req, "/R7 one done"}, done_cnt - d0, 1);
    chk({req, "/R2 load sets empty"}, tx_empty_o, 1);
    release_ss();
  endtask

  task automatic t_phase1_wait();
    set_mode(1'b0, 1'b1);
    host_wr(8'h96);
    ss_ni = 1'b0;
    wclk(2*H);
    chk("R4 no load before first edge", tx_empty_o, 0);
    chk("R8 oe with select", miso_oe_o, 1);
    release_ss();
    chk("R4 holding kept after idle select", tx_empty_o, 0);
    t_basic("R4", 1'b0, 1'b1, 8'h96, 8'hC3);
  endtask

  task automatic t_deferred();
    logic [7:0] got;
    set_mode(1'b0, 1'b1);
    host_wr(8'h5A);
    run_frame(8'h24, 8, 1'b1, 8'h81, 1'b0, 8'h00, got);
    chk("R6 current frame untouched", got, 8'h5A);
    chk("R6 write waits", tx_empty_o, 0);
    chk("R5 rx first", rx_data_o, 8'h24);
    run_frame(8'hE7, 8, 1'b0, 8'h00, 1'b0, 8'h00, got);
    chk("R6 deferred byte sent", got, 8'h81);
    chk("R4 back-to-back rx", rx_data_o, 8'hE7);
    chk("R6 empty after load", tx_empty_o, 1);
    release_ss();
  endtask

  task automatic t_filler();
    logic [7:0] got;
    set_mode(1'b0, 1'b0);
    chk("R9 empty before", tx_empty_o, 1);
    run_frame(8'h5C, 8, 1'b0, 8'h00, 1'b0, 8'h00, got);
    chk("R9 filler", got, 8'hFF);
    chk("R9 rx", rx_data_o, 8'h5C);
    release_ss();
  endtask

  task automatic t_abort();
    logic [7:0] got;
    int d0;
    set_mode(1'b0, 1'b0);
    host_wr(8'h11);
    d0 = done_cnt;
    run_frame(8'hF0, 3, 1'b0, 8'h00, 1'b0, 8'h00, got);
    chk("R8 partial bits", got[7:5], 3'b000);
    release_ss();
    chk("R8 oe off", miso_oe_o, 0);
    chk("R8 no done", done_cnt - d0, 0);
    chk("R8 rx unchanged", rx_data_o, 8'h5C);
    t_basic("R8 fresh frame", 1'b0, 1'b0, 8'h77, 8'h2D);
  endtask

  task automatic t_collision();
    logic [7:0] got;
    set_mode(1'b0, 1'b0);
    host_wr(8'h3A);
    run_frame(8'h00, 8, 1'b0, 8'h00, 1'b1, 8'hC5, got);
    chk("R10 old byte sent", got, 8'h3A);
    chk("R10 new byte held", tx_empty_o, 0);
    release_ss();
    run_frame(8'h0F, 8, 1'b0, 8'h00, 1'b0, 8'h00, got);
    chk("R10 new byte next frame", got, 8'hC5);
    chk("R10 empty after", tx_empty_o, 1);
    release_ss();
  endtask

  initial begin
    rst_ni = 1'b0; cpol_i = 1'b0; cpha_i = 1'b0; wr_data_i = '0; wr_en_i = 1'b0;
    sck_i = 1'b0; ss_ni = 1'b1; mosi_i = 1'b0;
    wclk(4);
    rst_ni = 1'b1;
    wclk(2);
    t_reset();
    t_basic("R3", 1'b0, 1'b0, 8'hA5, 8'h3C);
    t_phase1_wait();
    t_deferred();
    t_filler();
    t_abort();
    t_collision();
    t_basic("R11 cpha0", 1'b1, 1'b0, 8'h4E, 8'h71);
    t_basic("R11 cpha1", 1'b1, 1'b1, 8'hB2, 8'h9D);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule